// File: doc/BRIEF.md
# Floating-Point Control and Status Word

This block keeps the single control/status word of a scalar floating-point unit. Software reaches it through a control-register read port and write port that are both indexed by a 5-bit register number. Only register 31 holds state. The arithmetic datapath reports the exceptions raised by each operation on an update port. Compare instructions write one of eight condition codes through a separate port. Branch and conditional-move logic read a selected condition code through a test port.

The word carries the following fields:

| Bits | Field |
|------|-------|
| 1:0 | rounding mode |
| 6:2 | sticky flags |
| 11:7 | trap enables |
| 16:12 | per-operation causes |
| 17 | unimplemented-operation cause |
| 23 | condition code 0 |
| 24 | flush control |
| 31:25 | condition codes 1..7 |

Inside each five-bit group the order is inexact, underflow, overflow, divide-by-zero, invalid, from low to high. A two-state machine tracks whether the stored word asks for a trap. It has a RUN state (no enabled cause) and a HOLD state (trap requested). On every clock it takes the transition RUN->HOLD or HOLD->HOLD when the next word has an enabled cause. It takes HOLD->RUN or RUN->RUN when the next word has none. Alongside that state, a combinational commit-inhibit output tells the datapath in the same cycle that the result of the operation now being reported must not be written back.

Top module: `fcsr_unit`

## Requirements
- R1: After reset the word is zero, round_mode is 0, cc_bits is 0 and trap_req is low.
- R2: Reading register 31 returns the stored word. Reading any other register number (0 included) returns zero.
- R3: A write to register 31 changes only bits 1:0, 6:2, 11:7 and 24. Causes and condition codes keep their value. Writes to any other register number leave the word unchanged.
- R4: round_mode presents bits 1:0 with the encoding 0 nearest, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R5: On an operation update (op_valid), op_exc bits 4:0 (inexact, underflow, overflow, divide-by-zero, invalid) replace cause bits 16:12 and op_exc bit 5 replaces bit 17. Without op_valid, the causes are unchanged.
- R6: Flag bits 6:2 take the OR of their old value and op_exc bits 4:0. An operation never clears a flag.
- R7: trap_req is high in the cycle after the word comes to hold a cause bit whose enable bit (five positions lower) is set, or bit 17 set. Otherwise trap_req is low.
- R8: commit_inhibit is high, in the same cycle as op_valid, exactly when that operation's causes would request a trap under the enables in effect. An inhibited operation is followed by trap_req high.
- R9: A register-31 write that enables a bit whose cause is already set raises trap_req on the next cycle, with no operation in between.
- R10: A condition-code update with index k sets bit 23 for k=0 and bit 24+k otherwise to cc_wr_val. The other codes are unchanged, and cc_bits[k] shows code k.
- R11: cc_test_bit returns the condition code chosen by cc_test_idx.
- R12: When a register-31 write and an operation update land in the same cycle, the written flags are taken first and the operation's exceptions are OR-ed on top. The causes come from the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control-register write strobe |
| cfg_wr_idx | input | 5 | Control-register number for the write |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_idx | input | 5 | Control-register number for the read |
| cfg_rd_data | output | 32 | Read data (combinational) |
| op_valid | input | 1 | An arithmetic operation reports its exceptions |
| op_exc | input | 6 | Exceptions of that operation: {unimpl, invalid, divzero, overflow, underflow, inexact} |
| cc_wr_en | input | 1 | Condition-code update strobe |
| cc_wr_idx | input | 3 | Condition code to update |
| cc_wr_val | input | 1 | Value for that condition code |
| cc_test_idx | input | 3 | Condition code to test |
| cc_test_bit | output | 1 | Value of the tested condition code |
| round_mode | output | 2 | Current rounding mode |
| cc_bits | output | 8 | All condition codes, index order |
| trap_req | output | 1 | Exception request |
| commit_inhibit | output | 1 | Suppress write-back of the current operation |

## Verification
A corrupted field in the stored word surfaces on the register-31 read port on the first cycle after the update that caused it. A rounding-mode or condition-code fault also appears at once on round_mode, cc_bits and cc_test_bit. A wrong cause or enable bit shows up one clock later as a mismatched trap_req. A wrong enable path shows in the same cycle as a mismatched commit_inhibit. Sticky flags that lose a bit stay wrong on every later read until software rewrites them, so a single read after a sequence of operations exposes the fault.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned RM_LSB     = 0;
    localparam int unsigned RM_W       = 2;
    localparam int unsigned EXC_N      = 5;
    localparam int unsigned FLAG_LSB   = 2;
    localparam int unsigned ENA_LSB    = 7;
    localparam int unsigned CAUSE_LSB  = ENA_LSB + EXC_N;
    localparam int unsigned UNIMPL_POS = CAUSE_LSB + EXC_N;
    localparam int unsigned CC0_POS    = 23;
    localparam int unsigned FLUSH_POS  = 24;
    localparam int unsigned NUM_CC     = 8;
    localparam int unsigned CC_IDX_W   = $clog2(NUM_CC);

    typedef enum logic {
        TR_RUN  = 1'b0,
        TR_HOLD = 1'b1
    } trap_state_e;

    // Bit position of condition code k in the word.
    function automatic int unsigned cc_pos(input int unsigned k);
        return (k == 0) ? CC0_POS : (FLUSH_POS + k);
    endfunction

    // Bits that a software write may change.
    function automatic logic [WORD_W-1:0] wr_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        m[RM_LSB +: RM_W]    = '1;
        m[FLAG_LSB +: EXC_N] = '1;
        m[ENA_LSB +: EXC_N]  = '1;
        m[FLUSH_POS]         = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/fcsr_wmerge.sv
module fcsr_wmerge
    import fcsr_pkg::*;
(
    input  logic [WORD_W-1:0] cur_word,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] merged
);
    localparam logic [WORD_W-1:0] MASK = wr_mask();

    always_comb begin
        if (wr_hit)
            merged = (cur_word & ~MASK) | (wr_data & MASK);
        else
            merged = cur_word;
    end
endmodule

// File: rtl/fcsr_exc.sv
module fcsr_exc
    import fcsr_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic              op_valid,
    input  logic [EXC_N:0]    op_exc,
    output logic [WORD_W-1:0] word_out,
    output logic              trap_next,
    output logic              inhibit
);
    logic [EXC_N-1:0] armed;

    always_comb begin
        word_out = word_in;
        if (op_valid) begin
            word_out[CAUSE_LSB +: EXC_N] = op_exc[EXC_N-1:0];
            word_out[UNIMPL_POS]         = op_exc[EXC_N];
            word_out[FLAG_LSB +: EXC_N]  = word_in[FLAG_LSB +: EXC_N] | op_exc[EXC_N-1:0];
        end
    end

    always_comb begin
        armed     = word_out[CAUSE_LSB +: EXC_N] & word_out[ENA_LSB +: EXC_N];
        trap_next = (|armed) | word_out[UNIMPL_POS];
        inhibit   = op_valid & trap_next;
    end
endmodule

// File: rtl/fcsr_ccbank.sv
module fcsr_ccbank
    import fcsr_pkg::*;
#(
    parameter int unsigned N_CC  = NUM_CC,
    parameter int unsigned SEL_W = CC_IDX_W
)(
    input  logic [WORD_W-1:0] word_in,
    input  logic              cc_wr_en,
    input  logic [SEL_W-1:0]  cc_wr_idx,
    input  logic              cc_wr_val,
    input  logic [SEL_W-1:0]  cc_test_idx,
    input  logic [WORD_W-1:0] word_cur,
    output logic [WORD_W-1:0] word_out,
    output logic [N_CC-1:0]   cc_vec,
    output logic              cc_test_bit
);
    logic [N_CC-1:0] upd;

    for (genvar k = 0; k < N_CC; k++) begin : g_cc
        localparam int unsigned P = cc_pos(k);
        assign cc_vec[k] = word_cur[P];
        assign upd[k]    = cc_wr_en && (cc_wr_idx == SEL_W'(k));
    end

    always_comb begin
        word_out = word_in;
        for (int k = 0; k < N_CC; k++) begin
            if (upd[k])
                word_out[cc_pos(k)] = cc_wr_val;
        end
    end

    assign cc_test_bit = cc_vec[cc_test_idx];
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
    import fcsr_pkg::*;
#(
    parameter int unsigned IDX_W   = 5,
    parameter int unsigned CSR_SEL = 31
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [IDX_W-1:0]    cfg_wr_idx,
    input  logic [WORD_W-1:0]   cfg_wr_data,
    input  logic [IDX_W-1:0]    cfg_rd_idx,
    output logic [WORD_W-1:0]   cfg_rd_data,
    input  logic                op_valid,
    input  logic [EXC_N:0]      op_exc,
    input  logic                cc_wr_en,
    input  logic [CC_IDX_W-1:0] cc_wr_idx,
    input  logic                cc_wr_val,
    input  logic [CC_IDX_W-1:0] cc_test_idx,
    output logic                cc_test_bit,
    output logic [RM_W-1:0]     round_mode,
    output logic [NUM_CC-1:0]   cc_bits,
    output logic                trap_req,
    output logic                commit_inhibit
);
    localparam logic [IDX_W-1:0] CSR_ID = IDX_W'(CSR_SEL);

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] w_merged;
    logic [WORD_W-1:0] w_exc;
    logic [WORD_W-1:0] word_d;
    logic              trap_next;
    logic              wr_hit;
    trap_state_e       state_q;
    trap_state_e       state_d;

    assign wr_hit = cfg_wr_en && (cfg_wr_idx == CSR_ID);

    fcsr_wmerge u_wmerge (
        .cur_word (word_q),
        .wr_hit   (wr_hit),
        .wr_data  (cfg_wr_data),
        .merged   (w_merged)
    );

    fcsr_exc u_exc (
        .word_in   (w_merged),
        .op_valid  (op_valid),
        .op_exc    (op_exc),
        .word_out  (w_exc),
        .trap_next (trap_next),
        .inhibit   (commit_inhibit)
    );

    fcsr_ccbank #(.N_CC(NUM_CC), .SEL_W(CC_IDX_W)) u_cc (
        .word_in     (w_exc),
        .cc_wr_en    (cc_wr_en),
        .cc_wr_idx   (cc_wr_idx),
        .cc_wr_val   (cc_wr_val),
        .cc_test_idx (cc_test_idx),
        .word_cur    (word_q),
        .word_out    (word_d),
        .cc_vec      (cc_bits),
        .cc_test_bit (cc_test_bit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    // Trap-tracking state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TR_RUN;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        unique case (state_q)
            TR_RUN:  state_d = trap_next ? TR_HOLD : TR_RUN;
            TR_HOLD: state_d = trap_next ? TR_HOLD : TR_RUN;
            default: state_d = TR_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        trap_req    = (state_q == TR_HOLD);
        round_mode  = word_q[RM_LSB +: RM_W];
        cfg_rd_data = (cfg_rd_idx == CSR_ID) ? word_q : '0;
    end
endmodule

// File: rtl/fcsr_unit_chk.sv
module fcsr_unit_chk
    import fcsr_pkg::*;
#(
    parameter int unsigned IDX_W   = 5,
    parameter int unsigned CSR_SEL = 31
)(
    input logic                clk,
    input logic                rst_n,
    input logic [WORD_W-1:0]   word,
    input logic                cfg_wr_en,
    input logic [IDX_W-1:0]    cfg_wr_idx,
    input logic [IDX_W-1:0]    cfg_rd_idx,
    input logic [WORD_W-1:0]   cfg_rd_data,
    input logic                op_valid,
    input logic [EXC_N:0]      op_exc,
    input logic                cc_wr_en,
    input logic [NUM_CC-1:0]   cc_bits,
    input logic                trap_req,
    input logic                commit_inhibit
);
    localparam logic [IDX_W-1:0] CSR_ID = IDX_W'(CSR_SEL);

    // R2
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_idx != CSR_ID) |-> (cfg_rd_data == '0));

    // R5
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(word[UNIMPL_POS:CAUSE_LSB]));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr_en && cfg_wr_idx == CSR_ID) |=>
            ((word[FLAG_LSB +: EXC_N] & $past(word[FLAG_LSB +: EXC_N])) == $past(word[FLAG_LSB +: EXC_N])));

    // R7
    trap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req == ((|(word[CAUSE_LSB +: EXC_N] & word[ENA_LSB +: EXC_N])) | word[UNIMPL_POS]));

    // R8
    inhibit_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_inhibit |=> trap_req);

    // R8
    unimpl_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_exc[EXC_N]) |-> commit_inhibit);

    // R10
    cc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_wr_en |=> $stable(cc_bits));
endmodule

bind fcsr_unit fcsr_unit_chk #(.IDX_W(IDX_W), .CSR_SEL(CSR_SEL)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .word           (word_q),
    .cfg_wr_en      (cfg_wr_en),
    .cfg_wr_idx     (cfg_wr_idx),
    .cfg_rd_idx     (cfg_rd_idx),
    .cfg_rd_data    (cfg_rd_data),
    .op_valid       (op_valid),
    .op_exc         (op_exc),
    .cc_wr_en       (cc_wr_en),
    .cc_bits        (cc_bits),
    .trap_req       (trap_req),
    .commit_inhibit (commit_inhibit)
);

// File: tb/fcsr_unit_test.sv
`timescale 1ns/100ps
module fcsr_unit_test;
    localparam logic [31:0] WMASK = 32'h0100_0FFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [4:0]  cfg_wr_idx = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [4:0]  cfg_rd_idx = 5'd31;
    logic [31:0] cfg_rd_data;
    logic        op_valid = 1'b0;
    logic [5:0]  op_exc = '0;
    logic        cc_wr_en = 1'b0;
    logic [2:0]  cc_wr_idx = '0;
    logic        cc_wr_val = 1'b0;
    logic [2:0]  cc_test_idx = '0;
    logic        cc_test_bit;
    logic [1:0]  round_mode;
    logic [7:0]  cc_bits;
    logic        trap_req;
    logic        commit_inhibit;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_word = '0;

    typedef struct {
        logic [31:0] w;
        logic        t;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    fcsr_unit uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_idx(cfg_rd_idx), .cfg_rd_data(cfg_rd_data),
        .op_valid(op_valid), .op_exc(op_exc),
        .cc_wr_en(cc_wr_en), .cc_wr_idx(cc_wr_idx), .cc_wr_val(cc_wr_val),
        .cc_test_idx(cc_test_idx), .cc_test_bit(cc_test_bit),
        .round_mode(round_mode), .cc_bits(cc_bits),
        .trap_req(trap_req), .commit_inhibit(commit_inhibit)
    );

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    function automatic int ccp(input int k);
        return (k == 0) ? 23 : 24 + k;
    endfunction

    function automatic logic [7:0] cc_of(input logic [31:0] w);
        logic [7:0] c;
        for (int k = 0; k < 8; k++) c[k] = w[ccp(k)];
        return c;
    endfunction

    function automatic logic trap_of(input logic [31:0] w);
        return (|(w[16:12] & w[11:7])) | w[17];
    endfunction

    // Driver: one cycle of stimulus, expected state pushed to the scoreboard
    task automatic step(input logic wr, input logic [4:0] widx, input logic [31:0] wd,
                        input logic op, input logic [5:0] ex,
                        input logic ccw, input logic [2:0] cci, input logic ccv,
                        input string tag);
        logic [31:0] nw;
        logic        nt;
        exp_t        it;
        @(negedge clk); #1;
        cfg_wr_en = wr; cfg_wr_idx = widx; cfg_wr_data = wd;
        op_valid = op; op_exc = ex;
        cc_wr_en = ccw; cc_wr_idx = cci; cc_wr_val = ccv;
        nw = m_word;
        if (wr && widx == 5'd31) nw = (nw & ~WMASK) | (wd & WMASK);
        if (op) begin
            nw[16:12] = ex[4:0];
            nw[17]    = ex[5];
            nw[6:2]   = nw[6:2] | ex[4:0];
        end
        if (ccw) nw[ccp(int'(cci))] = ccv;
        nt = trap_of(nw);
        #0.5;
        check(commit_inhibit == (op && nt), {"R8 commit_inhibit ", tag},
              {31'd0, commit_inhibit}, {31'd0, op && nt});
        @(posedge clk); #1;
        cfg_wr_en = 1'b0; op_valid = 1'b0; cc_wr_en = 1'b0;
        it.w = nw; it.t = nt; it.tag = tag;
        q.push_back(it);
        m_word = nw;
    endtask

    // Monitor: pops expected state and compares the ports
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t it;
            it = q.pop_front();
            check(cfg_rd_data == it.w, {"word ", it.tag}, cfg_rd_data, it.w);
            check(trap_req == it.t, {"R7 trap_req ", it.tag}, {31'd0, trap_req}, {31'd0, it.t});
            check(round_mode == it.w[1:0], {"R4 round_mode ", it.tag}, {30'd0, round_mode}, {30'd0, it.w[1:0]});
            check(cc_bits == cc_of(it.w), {"R10 cc_bits ", it.tag}, {24'd0, cc_bits}, {24'd0, cc_of(it.w)});
        end
    end

    task automatic read_other(input logic [4:0] idx);
        @(negedge clk); #1;
        cfg_rd_idx = idx;
        #0.5;
        check(cfg_rd_data == 32'd0, "R2 read of non-31 register", cfg_rd_data, 32'd0);
        cfg_rd_idx = 5'd31;
    endtask

    task automatic test_cc(input logic [2:0] idx);
        @(negedge clk); #1;
        cc_test_idx = idx;
        #0.5;
        check(cc_test_bit == m_word[ccp(int'(idx))], "R11 cc_test_bit",
              {31'd0, cc_test_bit}, {31'd0, m_word[ccp(int'(idx))]});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_rd_data == 32'd0, "R1 word after reset", cfg_rd_data, 32'd0);
        check({trap_req, round_mode, cc_bits} == 11'd0, "R1 outputs after reset",
              {21'd0, trap_req, round_mode, cc_bits}, 32'd0);

        // R3 write all ones: only writable bits change; R4 mode 3
        step(1, 5'd31, 32'hFFFF_FFFF, 0, 6'd0, 0, 3'd0, 0, "R3 masked write");
        // R4 mode 1, clears flags and enables
        step(1, 5'd31, 32'h0000_0001, 0, 6'd0, 0, 3'd0, 0, "R4 toward zero");
        // R3 write to other index ignored
        step(1, 5'd5, 32'hFFFF_FFFF, 0, 6'd0, 0, 3'd0, 0, "R3 other index ignored");
        read_other(5'd0);
        read_other(5'd7);
        // R5 R6 operation updates
        step(0, 5'd0, 32'd0, 1, 6'b001000, 0, 3'd0, 0, "R5 divzero cause");
        step(0, 5'd0, 32'd0, 1, 6'b000000, 0, 3'd0, 0, "R6 clean op keeps flags");
        step(0, 5'd0, 32'd0, 1, 6'b000101, 0, 3'd0, 0, "R5 inexact overflow");
        // R9 enabling an existing cause
        step(1, 5'd31, 32'h0000_0081, 0, 6'd0, 0, 3'd0, 0, "R9 enable raises trap");
        step(0, 5'd0, 32'd0, 1, 6'b000000, 0, 3'd0, 0, "R7 clean op drops trap");
        step(0, 5'd0, 32'd0, 1, 6'b000001, 0, 3'd0, 0, "R8 enabled inexact");
        step(0, 5'd0, 32'd0, 1, 6'b100000, 0, 3'd0, 0, "R7 unimplemented");
        step(0, 5'd0, 32'd0, 1, 6'b000100, 0, 3'd0, 0, "R8 disabled overflow");
        // R10 R11 condition codes
        step(0, 5'd0, 32'd0, 0, 6'd0, 1, 3'd0, 1, "R10 cc0");
        step(0, 5'd0, 32'd0, 0, 6'd0, 1, 3'd7, 1, "R10 cc7");
        step(0, 5'd0, 32'd0, 0, 6'd0, 1, 3'd3, 1, "R10 cc3");
        test_cc(3'd0);
        test_cc(3'd3);
        test_cc(3'd5);
        test_cc(3'd7);
        step(0, 5'd0, 32'd0, 0, 6'd0, 1, 3'd0, 0, "R10 cc0 clear");
        test_cc(3'd0);
        // R12 simultaneous write and operation
        step(1, 5'd31, 32'h0000_0002, 1, 6'b010100, 0, 3'd0, 0, "R12 write plus op");
        step(0, 5'd0, 32'd0, 0, 6'd0, 0, 3'd0, 0, "idle");
        repeat (3) @(negedge clk);
        check(q.size() == 0, "scoreboard drained", q.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule